// File: doc/BRIEF.md
# Reset Cause and Soft Reset Control Register

This block is a 32-bit memory-mapped register that remembers why the system last came out of reset and lets software ask for a new reset. Five of its bits are meaningful. The top bit records a power-on reset. Two bits record resets caused by the power button and by the external-reset button; these are set by event inputs. Two more bits are soft-reset triggers that software sets by writing to them. The three cause bits are cleared by writing 1 to them. The two trigger bits can only be set by software. All other bits read as zero.

A write that sets either trigger bit produces a one-cycle system reset request on the following cycle. The system answers it with its own reset sequence, which is outside this block. A flag that only the power-on input clears tells the block whether the next reset is the first one since power-up. Only that first reset loads the register with the power-on cause alone. Every later reset keeps the recorded causes, so software can read them after the reset.

Top module: `reset_cause_ctrl`

## Requirements
- R1: Outside reset and power-on cycles, with no write and no event, the register holds its value, and `rd_data` bits 26..0 always read as zero.
- R2: The first `rst` cycle after a `por` cycle loads the register with 0x80000000 (bit 31 only), plus any event bits set in that same cycle.
- R3: A `rst` cycle after the first one leaves the register contents unchanged.
- R4: A `por` cycle leaves the register contents unchanged and re-arms the first-reset load for the next `rst` cycle.
- R5: Writing 1 to bit 31 (power-on cause), bit 28 (power-button cause) or bit 27 (external-button cause) clears that bit. Writing 0 to any of these bits leaves it unchanged.
- R6: Writing 1 to bit 30 (soft power-on trigger) or bit 29 (soft external trigger) sets that bit. Writing 0 to either bit leaves it unchanged.
- R7: A single write that clears cause bits and sets trigger bits applies both effects in the same cycle.
- R8: `cause_evt[1]` sets bit 28 and `cause_evt[0]` sets bit 27. If a write clears the same bit in the same cycle, the event wins.
- R9: A write with bit 30 or bit 29 set drives `sys_reset_req` high for exactly the following cycle. Any other cycle leaves it low.
- R10: A write made while `rst` or `por` is high has no effect on the register, and `sys_reset_req` is low in the cycle after any `rst` or `por` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| por | input | 1 | Synchronous power-on indication; re-arms the first-reset load |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| cause_evt | input | 2 | Button cause events: bit 1 sets bit 28, bit 0 sets bit 27 |
| rd_data | output | 32 | Current register value |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
There are two kinds of same-cycle collision. The first is a write landing in the same cycle as a cause event or a reset. The second is a single write that clears cause bits and sets trigger bits at once. The bench sweeps every combination of the five live bits as the starting state against every combination of the five live bits in the written value. It then runs a long pseudo-random run in which events, resets and power-on pulses collide freely with writes. Each cycle is judged against a bench model: power-on first, then reset, then the write's clear and set steps, then the event OR. The model checks both the register value and whether a request pulse appears.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned POS_PWR  = 31;
  localparam int unsigned POS_SPWR = 30;
  localparam int unsigned POS_SEXT = 29;
  localparam int unsigned POS_BPWR = 28;
  localparam int unsigned POS_BEXT = 27;
  localparam int unsigned EVT_W    = 2;

  typedef struct packed {
    logic pwr;
    logic soft_pwr;
    logic soft_ext;
    logic btn_pwr;
    logic btn_ext;
  } cause_t;

  function automatic cause_t unpack_word(input logic [REG_W-1:0] w);
    cause_t c;
    c.pwr      = w[POS_PWR];
    c.soft_pwr = w[POS_SPWR];
    c.soft_ext = w[POS_SEXT];
    c.btn_pwr  = w[POS_BPWR];
    c.btn_ext  = w[POS_BEXT];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_word(input cause_t c);
    logic [REG_W-1:0] w;
    w           = '0;
    w[POS_PWR]  = c.pwr;
    w[POS_SPWR] = c.soft_pwr;
    w[POS_SEXT] = c.soft_ext;
    w[POS_BPWR] = c.btn_pwr;
    w[POS_BEXT] = c.btn_ext;
    return w;
  endfunction
endpackage

// File: rtl/rstctl_first_flag.sv
module rstctl_first_flag (
  input  logic clk,
  input  logic rst,
  input  logic por,
  output logic load_first
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (por)      done_q <= 1'b0;
    else if (rst) done_q <= 1'b1;
  end

  assign load_first = rst && !por && !done_q;

  // R4: after a power-on cycle the next plain reset must perform the load
  assert_rearm_R4: assert property (@(posedge clk)
    por |=> (!rst || por || load_first));
  // R3: a reset following a load never loads again until power-on
  assert_once_R3: assert property (@(posedge clk)
    (rst && !por) |=> (!load_first || por));
endmodule

// File: rtl/rstctl_cause_reg.sv
module rstctl_cause_reg
  import rstctl_pkg::*;
(
  input  logic             clk,
  input  logic             load_first,
  input  logic             freeze,
  input  logic             wr_en,
  input  cause_t           wr_val,
  input  logic [EVT_W-1:0] evt,
  output cause_t           state
);
  cause_t nxt;

  always_comb begin
    nxt = state;
    if (load_first) begin
      nxt     = '0;
      nxt.pwr = 1'b1;
    end else if (!freeze && wr_en) begin
      nxt.pwr      = state.pwr     & ~wr_val.pwr;
      nxt.btn_pwr  = state.btn_pwr & ~wr_val.btn_pwr;
      nxt.btn_ext  = state.btn_ext & ~wr_val.btn_ext;
      nxt.soft_pwr = state.soft_pwr | wr_val.soft_pwr;
      nxt.soft_ext = state.soft_ext | wr_val.soft_ext;
    end
    nxt.btn_pwr = nxt.btn_pwr | evt[1];
    nxt.btn_ext = nxt.btn_ext | evt[0];
  end

  always_ff @(posedge clk) begin
    state <= nxt;
  end

  logic seen_load;
  always_ff @(posedge clk) begin
    if (load_first) seen_load <= 1'b1;
  end

  assert_first_R2: assert property (@(posedge clk)
    (load_first && evt == '0) |=> (state == cause_t'(5'b10000)));
  assert_w1c_R5: assert property (@(posedge clk) disable iff (freeze)
    (wr_en && wr_val.pwr) |=> !state.pwr);
  assert_set_R6: assert property (@(posedge clk) disable iff (freeze)
    (wr_en && wr_val.soft_pwr) |=> state.soft_pwr);
  assert_evt_R8: assert property (@(posedge clk)
    evt[1] |=> state.btn_pwr);
  assert_hold_R3: assert property (@(posedge clk)
    (seen_load && freeze && !load_first && evt == '0) |=> $stable(state));
endmodule

// File: rtl/rstctl_req_pulse.sv
module rstctl_req_pulse (
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic trig,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst || por) req <= 1'b0;
    else            req <= trig;
  end

  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst || por)
    trig |=> req);
  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst || por)
    !trig |=> !req);
  assert_rst_low_R10: assert property (@(posedge clk)
    (rst || por) |=> !req);
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import rstctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [EVT_W-1:0] cause_evt,
  output logic [REG_W-1:0] rd_data,
  output logic             sys_reset_req
);
  cause_t wr_val;
  cause_t state;
  logic   load_first;
  logic   freeze;
  logic   trig;

  assign wr_val = unpack_word(wr_data);
  assign freeze = rst || por;
  assign trig   = wr_en && !freeze && (wr_val.soft_pwr || wr_val.soft_ext);

  rstctl_first_flag u_flag (
    .clk        (clk),
    .rst        (rst),
    .por        (por),
    .load_first (load_first)
  );

  rstctl_cause_reg u_reg (
    .clk        (clk),
    .load_first (load_first),
    .freeze     (freeze),
    .wr_en      (wr_en),
    .wr_val     (wr_val),
    .evt        (cause_evt),
    .state      (state)
  );

  rstctl_req_pulse u_req (
    .clk  (clk),
    .rst  (rst),
    .por  (por),
    .trig (trig),
    .req  (sys_reset_req)
  );

  assign rd_data = pack_word(state);

  // R10: a write during reset must not alter the trigger bits
  assert_frozen_R10: assert property (@(posedge clk)
    (rst && !load_first && wr_en) |=> $stable(rd_data[POS_SPWR]));
endmodule

// File: tb/tb_reset_cause_ctrl.sv
module tb_reset_cause_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        por = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  cause_evt = '0;
  logic [31:0] rd_data;
  logic        sys_reset_req;

  always #4 clk = ~clk;

  reset_cause_ctrl dut (
    .clk(clk), .rst(rst), .por(por), .wr_en(wr_en), .wr_data(wr_data),
    .cause_evt(cause_evt), .rd_data(rd_data), .sys_reset_req(sys_reset_req)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] m_reg = '0;
  logic        m_flag = 1'b0;
  logic        m_valid = 1'b0;
  logic        m_req = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic p, input logic we,
                     input logic [31:0] wd, input logic [1:0] ev);
    string t;
    rst = r; por = p; wr_en = we; wr_data = wd; cause_evt = ev;
    if (p) begin
      m_flag = 1'b0; t = "R4";
    end else if (r && !m_flag) begin
      m_reg = 32'h8000_0000; m_flag = 1'b1; m_valid = 1'b1; t = "R2";
    end else if (r) begin
      t = we ? "R10" : "R3";
    end else if (we) begin
      m_reg = m_reg & ~(wd & 32'h9800_0000);
      m_reg = m_reg | (wd & 32'h6000_0000);
      if ((wd & 32'h9800_0000) != 0 && (wd & 32'h6000_0000) != 0) t = "R7";
      else if ((wd & 32'h9800_0000) != 0) t = "R5";
      else t = "R6";
    end else begin
      t = "R1";
    end
    m_reg = m_reg | {3'b0, ev, 27'b0};
    if (ev != 0 && !p && !(r && t == "R2")) t = "R8";
    m_req = !p && !r && we && (wd[30] || wd[29]);
    @(posedge clk);
    #1;
    if (m_valid) begin
      check(t, rd_data, m_reg);
      check("R1", {5'b0, rd_data[26:0]}, 32'h0);
    end
    check((p || r) ? "R10" : "R9", {31'b0, sys_reset_req}, {31'b0, m_req});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2;
    // power-on then first reset (R4, R2)
    cyc(0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // sweep start state s against written value w (R5, R6, R7, R9)
    for (int s = 0; s < 32; s++) begin
      for (int w = 0; w < 32; w++) begin
        logic [4:0] sb;
        logic [4:0] wb;
        sb = 5'(s);
        wb = 5'(w);
        cyc(0, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        if (!sb[4]) cyc(0, 0, 1, 32'h8000_0000, 0);
        if (sb[1] || sb[0]) cyc(0, 0, 0, 0, sb[1:0]);
        if (sb[3] || sb[2]) cyc(0, 0, 1, {1'b0, sb[3], sb[2], 29'b0}, 0);
        cyc(0, 0, 1, {wb, 27'b0} | (32'h05A5_A5A5 ^ 32'(w)), 0);
        cyc(0, 0, 0, 0, 0);
      end
    end
    // later resets keep contents, writes during reset ignored (R3, R10)
    cyc(0, 0, 0, 0, 2'b11);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 32'hFFFF_FFFF, 0);
    cyc(0, 1, 1, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 1, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // event versus write clear in the same cycle (R8)
    cyc(0, 0, 1, 32'h1800_0000, 2'b10);
    cyc(0, 0, 1, 32'h1800_0000, 2'b01);
    cyc(0, 0, 1, 32'h9800_0000, 0);
    // back-to-back trigger writes give back-to-back pulses (R9)
    cyc(0, 0, 1, 32'h4000_0000, 0);
    cyc(0, 0, 1, 32'h2000_0000, 0);
    cyc(0, 0, 0, 0, 0);
    // pseudo-random collisions
    for (int i = 0; i < 4000; i++) begin
      logic r;
      logic p;
      logic we;
      logic [1:0] ev;
      seed = seed * 32'd1664525 + 32'd1013904223;
      r  = (seed[7:4] == 4'd0);
      p  = (seed[13:8] == 6'd0);
      we = seed[14];
      ev = (seed[17:15] == 3'd0) ? seed[19:18] : 2'b00;
      seed = seed * 32'd1664525 + 32'd1013904223;
      cyc(r, p, we, seed, ev);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule